// File: doc/BRIEF.md
# Eight-Source Core Interrupt Controller

This block keeps the pending state of eight interrupt sources for a small processor core and decides which one the sequencer is offered next. Software uses one 16-bit force/clear word to raise or drop any pending bit. Two of the sources are reached only through that word. Three active-low external request pins each have their own edge or level sensitivity. Three internal request lines are single-cycle pulses that are latched. One of the external pins is the shared request of the peripheral interrupt controller, and its vector address is 0x04.

An enable mask gates the pending set. The enabled request with the lowest index wins, and its vector address is four times its index. The sequencer accepts the request with `ack` and signals the end of a service routine with `rti`. A control word chooses the pin sensitivities and whether a more urgent request may preempt a routine that is already running.

Top module: `irqc_top`

## Requirements
- R1: After reset nothing is latched pending, nothing is in service, every pin is level sensitive, nesting is off and `irq_valid` is low.
- R2: A write with `wr_sel`=0 is a force/clear word. Bit i (0..7) clears the latched pending bit of source i, and bit 8+i sets it. When the same word carries both the clear bit and the force bit of a source, the source ends up pending.
- R3: A write with `wr_sel`=1 is the control word. Bits 0, 1 and 2 select the sensitivity of pins 0, 1 and 2 (1 = edge, 0 = level), bit 4 enables nesting, and the other bits are ignored.
- R4: Sources 3 and 4 are software interrupts. They become pending only through force bits 11 and 12, and their vectors are 0x0C and 0x10.
- R5: On an edge-sensitive pin, a high-to-low transition latches the source pending. The bit stays pending after the pin returns high, until it is acknowledged or cleared.
- R6: On a level-sensitive pin, the source is pending exactly while the pin is low. Falling edges latch nothing, and a clear write does not remove a request while the pin is held low.
- R7: Pin 0 drives source 0. Pin 2, the shared peripheral request, drives source 1 with vector 0x04. Pin 1 drives source 2. Pulses on `int_req[0..2]` latch sources 5, 6 and 7.
- R8: The presented source is the lowest-index pending source whose `mask` bit is 1, and `irq_vec` is four times its index. A masked source is never presented.
- R9: `ack` while `irq_valid` is high clears the latched pending bit of `irq_id` and marks that source in service. `ack` while `irq_valid` is low has no effect.
- R10: With nesting off, nothing is presented while any source is in service. `rti` ends the service of the lowest-index source in service.
- R11: With nesting on, a source is presented while others are in service only if its index is below every in-service index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = force/clear word, 1 = control word |
| wr_data | input | 16 | Write data |
| irq_pin_n | input | 3 | Active-low external request pins |
| int_req | input | 3 | Internal request pulses for sources 5 to 7 |
| mask | input | 8 | Per-source enable, 1 = enabled |
| ack | input | 1 | Sequencer accepts the presented request |
| rti | input | 1 | Return from interrupt |
| irq_valid | output | 1 | A request is presented |
| irq_id | output | 3 | Index of the presented source |
| irq_vec | output | 8 | Vector word address of the presented source |

## Verification
The bench builds the block with its default 8-bit vector width and a slot stride of 4. With these values every vector from 0x00 to 0x1C can be compared as an exact byte. Directed sequences cover the corner cases: a software force while a routine is in service, clear and force in the same write, a clear written while a level pin is held low, and preemption under nesting. Random writes to both registers, together with random pins, pulses, mask, `ack` and `rti`, then move the controller through both sensitivities and both nesting modes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC = 8;
  localparam int NPIN = 3;
  localparam int NINT = 3;
  localparam int ID_W = $clog2(NSRC);

  typedef enum logic [1:0] {SRC_EXT, SRC_SOFT, SRC_INT} src_kind_e;

  function automatic src_kind_e kind_of(int idx);
    if (idx <= 2) return SRC_EXT;
    if (idx <= 4) return SRC_SOFT;
    return SRC_INT;
  endfunction

  // pin 2 carries the shared peripheral request and lands on source 1
  function automatic int pin_of(int idx);
    if (idx == 1) return 2;
    if (idx == 2) return 1;
    return 0;
  endfunction

  function automatic int line_of(int idx);
    return (idx >= 5) ? idx - 5 : 0;
  endfunction

  function automatic logic [ID_W-1:0] lowest_set(logic [NSRC-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = ID_W'(i);
    return r;
  endfunction

  function automatic logic [NSRC-1:0] lowest_bit(logic [NSRC-1:0] v);
    return v & (~v + NSRC'(1));
  endfunction
endpackage

// File: rtl/irqc_pin_sense.sv
module irqc_pin_sense #(
  parameter int NP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pin_n,
  input  logic [NP-1:0] edge_mode,
  output logic [NP-1:0] fall_set,
  output logic [NP-1:0] lvl_req
);
  logic [NP-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '1;
    else        pin_q <= pin_n;
  end

  assign fall_set = pin_q & ~pin_n & edge_mode;
  assign lvl_req  = ~pin_n & ~edge_mode;
endmodule

// File: rtl/irqc_pend_cell.sv
module irqc_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic lvl_req,
  input  logic clr,
  input  logic ack_clr,
  output logic pend
);
  logic lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= (lat_q & ~(clr | ack_clr)) | set_evt;
  end

  assign pend = lat_q | lvl_req;
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0] cand,
  input  logic [NSRC-1:0] active,
  input  logic            nest_en,
  output logic            valid,
  output logic [ID_W-1:0] id
);
  logic [ID_W-1:0] act_id;
  logic            idle;

  assign id     = lowest_set(cand);
  assign act_id = lowest_set(active);
  assign idle   = (active == '0);
  assign valid  = (|cand) && (idle || (nest_en && (id < act_id)));
endmodule

// File: rtl/irqc_svc_track.sv
module irqc_svc_track
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [ID_W-1:0] take_id,
  input  logic            rti,
  output logic [NSRC-1:0] active
);
  logic [NSRC-1:0] done_mask;
  logic [NSRC-1:0] new_mask;

  assign done_mask = rti  ? lowest_bit(active) : '0;
  assign new_mask  = take ? (NSRC'(1) << take_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= '0;
    else        active <= (active & ~done_mask) | new_mask;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int VEC_STRIDE = 4,
  parameter int WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NPIN-1:0]   irq_pin_n,
  input  logic [NINT-1:0]   int_req,
  input  logic [NSRC-1:0]   mask,
  input  logic              ack,
  input  logic              rti,
  output logic              irq_valid,
  output logic [ID_W-1:0]   irq_id,
  output logic [VEC_W-1:0]  irq_vec
);
  localparam int NEST_BIT = 4;

  logic [NPIN-1:0] edge_mode;
  logic            nest_en;
  logic            wr_fc;
  logic            wr_ctl;
  logic [NSRC-1:0] force_bits;
  logic [NSRC-1:0] clr_bits;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] active;
  logic [NPIN-1:0] fall_set;
  logic [NPIN-1:0] lvl_req;
  logic            take;

  assign wr_fc      = wr_en & ~wr_sel;
  assign wr_ctl     = wr_en & wr_sel;
  assign force_bits = wr_fc ? wr_data[2*NSRC-1:NSRC] : '0;
  assign clr_bits   = wr_fc ? wr_data[NSRC-1:0]      : '0;
  assign take       = ack & irq_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_mode <= '0;
      nest_en   <= 1'b0;
    end else if (wr_ctl) begin
      edge_mode <= wr_data[NPIN-1:0];
      nest_en   <= wr_data[NEST_BIT];
    end
  end

  irqc_pin_sense #(.NP(NPIN)) u_pins (
    .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n), .edge_mode(edge_mode),
    .fall_set(fall_set), .lvl_req(lvl_req)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic set_evt;
    logic lvl_i;
    logic ack_i;
    if (kind_of(i) == SRC_EXT) begin : g_ext
      assign set_evt = fall_set[pin_of(i)] | force_bits[i];
      assign lvl_i   = lvl_req[pin_of(i)];
    end else if (kind_of(i) == SRC_INT) begin : g_int
      assign set_evt = int_req[line_of(i)] | force_bits[i];
      assign lvl_i   = 1'b0;
    end else begin : g_soft
      assign set_evt = force_bits[i];
      assign lvl_i   = 1'b0;
    end
    assign ack_i = take && (irq_id == ID_W'(i));
    irqc_pend_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .lvl_req(lvl_i),
      .clr(clr_bits[i]), .ack_clr(ack_i), .pend(pend[i])
    );
  end

  irqc_prio_pick u_pick (
    .cand(pend & mask), .active(active), .nest_en(nest_en),
    .valid(irq_valid), .id(irq_id)
  );

  irqc_svc_track u_svc (
    .clk(clk), .rst_n(rst_n), .take(take), .take_id(irq_id), .rti(rti),
    .active(active)
  );

  assign irq_vec = VEC_W'(irq_id) * VEC_W'(VEC_STRIDE);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_sel,
  input logic [15:0]     wr_data,
  input logic [NSRC-1:0] mask,
  input logic            ack,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] active,
  input logic            nest_en,
  input logic            irq_valid,
  input logic [ID_W-1:0] irq_id
);
  p_presented_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (mask[irq_id] && pend[irq_id]));

  p_no_offer_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !nest_en) |-> (active == '0));

  p_preempt_needs_nest_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && active != '0) |-> (nest_en && !active[irq_id]));

  p_ack_in_service_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_valid) |=> active[$past(irq_id)]);

  p_soft3_by_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[3]) |-> $past(wr_en && !wr_sel && wr_data[11]));

  p_soft4_by_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[4]) |-> $past(wr_en && !wr_sel && wr_data[12]));
endmodule

bind irqc_top irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .mask(mask), .ack(ack), .pend(pend), .active(active), .nest_en(nest_en),
  .irq_valid(irq_valid), .irq_id(irq_id)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  irq_pin_n = 3'b111;
  logic [2:0]  int_req = '0;
  logic [7:0]  mask = 8'hFF;
  logic        ack = 1'b0;
  logic        rti = 1'b0;
  logic        irq_valid;
  logic [2:0]  irq_id;
  logic [7:0]  irq_vec;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // bench-side model state
  bit [7:0] m_lat = '0;
  bit [7:0] m_act = '0;
  bit [2:0] m_edge = '0;
  bit       m_nest = 1'b0;
  bit [2:0] m_pinq = 3'b111;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_pin_n(irq_pin_n), .int_req(int_req), .mask(mask), .ack(ack), .rti(rti),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_vec(irq_vec)
  );

  function automatic int src_pin(int s);
    case (s)
      0: return 0;
      1: return 2;
      2: return 1;
      default: return -1;
    endcase
  endfunction

  function automatic bit [7:0] model_pend();
    bit [7:0] p;
    p = m_lat;
    for (int s = 0; s < 3; s++)
      if (!m_edge[src_pin(s)] && !irq_pin_n[src_pin(s)]) p[s] = 1'b1;
    return p;
  endfunction

  function automatic int first_one(bit [7:0] v);
    for (int s = 0; s < 8; s++) if (v[s]) return s;
    return 8;
  endfunction

  function automatic bit model_valid();
    int c;
    c = first_one(model_pend() & mask);
    if (c == 8) return 1'b0;
    if (m_act == 0) return 1'b1;
    return m_nest && (c < first_one(m_act));
  endfunction

  task automatic check(string tag, bit ev, int eid);
    checks++;
    if (irq_valid !== ev || (ev && (irq_id !== eid[2:0] || irq_vec !== 8'(eid * 4)))) begin
      failures++;
      $display("FAIL %s: valid=%0b id=%0d vec=0x%02h expected valid=%0b id=%0d vec=0x%02h",
               tag, irq_valid, irq_id, irq_vec, ev, eid, 8'(eid * 4));
    end
  endtask

  task automatic model_update();
    bit take;
    int cid;
    bit [7:0] setv, clrv;
    take = ack && model_valid();
    cid = first_one(model_pend() & mask);
    setv = '0; clrv = '0;
    if (wr_en && !wr_sel) begin setv = wr_data[15:8]; clrv = wr_data[7:0]; end
    for (int s = 0; s < 3; s++)
      if (m_edge[src_pin(s)] && m_pinq[src_pin(s)] && !irq_pin_n[src_pin(s)]) setv[s] = 1'b1;
    for (int s = 5; s < 8; s++) if (int_req[s-5]) setv[s] = 1'b1;
    if (take) clrv[cid] = 1'b1;
    m_lat = (m_lat & ~clrv) | setv;
    if (rti && m_act != 0) m_act[first_one(m_act)] = 1'b0;
    if (take) m_act[cid] = 1'b1;
    if (wr_en && wr_sel) begin m_edge = wr_data[2:0]; m_nest = wr_data[4]; end
    m_pinq = irq_pin_n;
  endtask

  // compare against the model, then advance one clock
  task automatic step(string tag);
    int cid;
    #1;
    cid = first_one(model_pend() & mask);
    check(tag, model_valid(), cid);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_data = '0; int_req = '0; ack = 0; rti = 0;
  endtask

  task automatic fc_write(logic [15:0] d, string tag);
    wr_en = 1; wr_sel = 0; wr_data = d; step(tag); idle();
  endtask

  task automatic ctl_write(logic [15:0] d, string tag);
    wr_en = 1; wr_sel = 1; wr_data = d; step(tag); idle();
  endtask

  task automatic settle_check(string tag, bit ev, int eid);
    #1; check(tag, ev, eid);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1ACE));
    repeat (3) @(negedge clk);
    settle_check("R1 in reset", 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    settle_check("R1 after reset", 1'b0, 0);

    // software interrupts
    fc_write(16'h0800, "R4");
    settle_check("R4 force bit 11", 1'b1, 3);
    ack = 1; step("R9"); idle();
    settle_check("R10 busy blocks", 1'b0, 0);
    ack = 1; step("R9"); idle();
    settle_check("R9 ack while idle ignored", 1'b0, 0);
    fc_write(16'h1000, "R4");
    settle_check("R10 force while busy", 1'b0, 0);
    rti = 1; step("R10"); idle();
    settle_check("R4 force bit 12 after rti", 1'b1, 4);
    fc_write(16'h0010, "R2");
    settle_check("R2 clear bit 4", 1'b0, 0);
    fc_write(16'h0202, "R2");
    settle_check("R2 force beats clear", 1'b1, 1);
    fc_write(16'h0002, "R2");
    settle_check("R2 clear bit 1", 1'b0, 0);

    // level mode on the shared peripheral pin
    irq_pin_n = 3'b011;
    settle_check("R7 pin2 to source 1", 1'b1, 1);
    fc_write(16'h0002, "R6");
    settle_check("R6 clear while low", 1'b1, 1);
    irq_pin_n = 3'b111;
    settle_check("R6 released pin", 1'b0, 0);
    irq_pin_n = 3'b101; step("R6"); irq_pin_n = 3'b111;
    settle_check("R6 level edge not latched", 1'b0, 0);

    // edge mode
    ctl_write(16'h00E7, "R3");
    irq_pin_n = 3'b110; step("R5");
    settle_check("R5 falling edge", 1'b1, 0);
    irq_pin_n = 3'b111; step("R5");
    settle_check("R5 held after release", 1'b1, 0);
    fc_write(16'h0001, "R2");
    settle_check("R5 cleared by write", 1'b0, 0);
    irq_pin_n = 3'b101; step("R7"); irq_pin_n = 3'b111;
    settle_check("R7 pin1 to source 2", 1'b1, 2);
    fc_write(16'h0004, "R2");

    // internal pulses and mask
    int_req = 3'b001; step("R7"); idle();
    settle_check("R7 int line 0", 1'b1, 5);
    mask = 8'hDF;
    settle_check("R8 masked", 1'b0, 0);
    mask = 8'hFF;

    // nesting
    ctl_write(16'h0017, "R3");
    ack = 1; step("R9"); idle();
    fc_write(16'h8400, "R11");
    settle_check("R11 higher preempts", 1'b1, 2);
    ack = 1; step("R9"); idle();
    settle_check("R11 lower waits", 1'b0, 0);
    rti = 1; step("R10"); idle();
    settle_check("R11 still under source 5", 1'b0, 0);
    rti = 1; step("R10"); idle();
    settle_check("R8 source 7 after return", 1'b1, 7);
    fc_write(16'h0080, "R2");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      wr_en = (r < 8);
      wr_sel = (r < 3);
      wr_data = 16'($urandom);
      int_req = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b000;
      if ($urandom_range(0, 5) == 0) irq_pin_n = 3'($urandom);
      mask = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF;
      ack = ($urandom_range(0, 2) == 0);
      rti = ($urandom_range(0, 4) == 0);
      step("R8 random");
    end
    idle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule